// File: doc/BRIEF.md
# Strap-Loaded Configuration Register File

This block keeps the operating settings of a high-speed signal conditioner: an edge-boost code, a DC-boost code, a receive-sensitivity code and a configuration-active flag. Nothing is loaded while reset is held. On the first clock edge after reset is released, the block reads the decoded strap levels once and turns them into register values through fixed per-level tables. The straps are a 2-bit boost level, a float indication that forces the top boost level, and a tri-level sensitivity strap.

On that same edge the block samples the idle levels of the two-wire serial clock and data lines. Only when both are high does it open its byte-wide register port to a serial slave front end. That front end presents a 7-bit device address, a register offset, write data and single-cycle write and read strobes. When serial access is closed, the values taken from the straps stay fixed until the next reset. While the configuration-active flag is set, the downstream mode controller is held.

Top module: `strap_cfg_regs`

## Requirements
- R1: The edge-boost output, register 0x01 bits 7:4, loads from the effective boost level at reset release: level 0 gives 0x0, level 1 gives 0x3, level 2 gives 0x6 and level 3 gives 0xA.
- R2: The DC-boost output, register 0x0E bits 3:0, loads from the effective boost level at reset release: level 0 gives 0x0, levels 1 and 2 give 0x2, and level 3 gives 0x6.
- R3: The sensitivity output, register 0x25 bits 7:0, loads from the sensitivity strap, encoded 2'b00 low, 2'b01 mid, 2'b10 high and 2'b11 floating. Low gives 0x00, mid or floating gives 0x33, and high gives 0x66.
- R4: When boost_float_i is 1 at reset release, the effective boost level is 3, whatever boost_lvl_i holds.
- R5: The straps are sampled only on the first clock edge after reset release. Later strap changes leave all outputs unchanged until the next reset.
- R6: Serial access is open only if scl_idle_i and sda_idle_i are both 1 at reset release. When access is closed, writes change nothing and reads return 0x00.
- R7: Only accesses with dev_addr_i equal to 0x2C act. Any other device address changes nothing and reads 0x00.
- R8: cfg_active_o (register 0x03 bit 0) is 1 during reset. After reset release it is 1 in serial mode and 0 otherwise. Writing bit 0 of 0x03 sets or clears it on the next edge.
- R9: Bits of the four implemented registers that are not decoded are writable and read back as written, with reset value 0. Writes to any other offset change no register, and reads of any other offset return 0x00.
- R10: reg_rdata_o is registered. It updates on the clock edge that samples reg_rd_i and holds its value while reg_rd_i is 0.
- R11: A write to an implemented register drives the matching output field from the next edge onward: 0x01 bits 7:4, 0x0E bits 3:0, 0x25 bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boost_lvl_i | input | 2 | Decoded boost strap level |
| boost_float_i | input | 1 | Boost strap left open; forces level 3 |
| sens_lvl_i | input | 2 | Decoded sensitivity strap (00 low, 01 mid, 10 high, 11 open) |
| scl_idle_i | input | 1 | Sampled idle level of the serial clock line |
| sda_idle_i | input | 1 | Sampled idle level of the serial data line |
| dev_addr_i | input | 7 | Device address of the current serial transaction |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 8 | Write data byte |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_rd_i | input | 1 | Read strobe, one cycle |
| reg_rdata_o | output | 8 | Registered read data |
| edge_boost_o | output | 4 | Edge-boost code |
| dc_boost_o | output | 4 | DC-boost code |
| sens_o | output | 8 | Receive-sensitivity code |
| cfg_active_o | output | 1 | Configuration active; holds the mode controller |

## Verification
The bench uses the default parameters: four registers at offsets 0x01, 0x03, 0x0E and 0x25, device address 0x2C and an 8-bit data path. With these values every row of the boost and sensitivity tables is reachable, including the floating boost strap and the floating sensitivity code. The same settings let the bench reach both idle-level cases that close serial access and the unmapped offset 0x02 that sits between two live registers. Because the offsets are sparse, a decoder that drops an address bit would alias onto a live register, and the reserved-bit read-back checks would catch it.

// File: rtl/strap_cfg_pkg.sv
package strap_cfg_pkg;
  localparam int NREG     = 4;
  localparam int DW       = 8;
  localparam int AW       = 8;
  localparam int REG_EDGE = 0;
  localparam int REG_CFG  = 1;
  localparam int REG_DC   = 2;
  localparam int REG_SENS = 3;

  localparam logic [NREG-1:0][AW-1:0] REG_OFFS = {8'h25, 8'h0E, 8'h03, 8'h01};
  localparam logic [NREG-1:0][DW-1:0] REG_RST  = {8'h00, 8'h00, 8'h01, 8'h00};

  function automatic logic [3:0] edge_code(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 4'h0;
      2'd1:    return 4'h3;
      2'd2:    return 4'h6;
      default: return 4'hA;
    endcase
  endfunction

  function automatic logic [3:0] dc_code(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return 4'h0;
      2'd3:    return 4'h6;
      default: return 4'h2;
    endcase
  endfunction

  function automatic logic [7:0] sens_code(input logic [1:0] lvl);
    case (lvl)
      2'b00:   return 8'h00;
      2'b10:   return 8'h66;
      default: return 8'h33;
    endcase
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_cfg_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               boost_lvl_i,
  input  logic                     boost_float_i,
  input  logic [1:0]               sens_lvl_i,
  input  logic                     scl_idle_i,
  input  logic                     sda_idle_i,
  output logic                     load_o,
  output logic                     loaded_o,
  output logic                     serial_en_o,
  output logic [NREG-1:0][DW-1:0]  init_o
);
  logic       loaded_q, serial_q;
  logic [1:0] eff_lvl;

  assign eff_lvl = boost_float_i ? 2'd3 : boost_lvl_i;

  always_comb begin
    init_o           = '0;
    init_o[REG_EDGE] = {edge_code(eff_lvl), 4'h0};
    init_o[REG_DC]   = {4'h0, dc_code(eff_lvl)};
    init_o[REG_SENS] = sens_code(sens_lvl_i);
    init_o[REG_CFG]  = {7'h00, scl_idle_i & sda_idle_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_q <= 1'b0;
      serial_q <= 1'b0;
    end else if (!loaded_q) begin
      loaded_q <= 1'b1;
      serial_q <= scl_idle_i & sda_idle_i;
    end
  end

  assign load_o      = !loaded_q;
  assign loaded_o    = loaded_q;
  assign serial_en_o = serial_q;

  p_load_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> loaded_q);
  p_mode_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_q |=> $stable(serial_q));
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int NREG = 4,
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter logic [NREG-1:0][AW-1:0] OFFS = '0,
  parameter logic [NREG-1:0][DW-1:0] RST  = '0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [NREG-1:0][DW-1:0]  init_i,
  input  logic                     access_en_i,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [NREG-1:0][DW-1:0]  regs_o,
  output logic [DW-1:0]            rdata_o
);
  logic [NREG-1:0] hit;
  logic [DW-1:0]   rd_val;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    assign hit[g] = (addr_i == OFFS[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= RST[g];
      else if (load_i)                            q <= init_i[g];
      else if (access_en_i && wr_en_i && hit[g])  q <= wdata_i;
    end
    assign regs_o[g] = q;
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREG; i++)
      if (hit[i]) rd_val = rd_val | regs_o[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= access_en_i ? rd_val : '0;
  end

  p_locked_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_en_i && !load_i) |=> $stable(regs_o));
  p_unmapped_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_en_i && wr_en_i && !(|hit) && !load_i) |=> $stable(regs_o));
  p_locked_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !access_en_i) |=> (rdata_o == '0));
  p_rdata_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/strap_cfg_regs.sv
module strap_cfg_regs
  import strap_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  boost_lvl_i,
  input  logic        boost_float_i,
  input  logic [1:0]  sens_lvl_i,
  input  logic        scl_idle_i,
  input  logic        sda_idle_i,
  input  logic [6:0]  dev_addr_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [7:0]  reg_wdata_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  output logic [7:0]  reg_rdata_o,
  output logic [3:0]  edge_boost_o,
  output logic [3:0]  dc_boost_o,
  output logic [7:0]  sens_o,
  output logic        cfg_active_o
);
  logic                    load, loaded, serial_en, access_en;
  logic [NREG-1:0][DW-1:0] init, regs;
  logic                    unused_bits;

  strap_capture u_cap (
    .clk_i, .rst_ni, .boost_lvl_i, .boost_float_i, .sens_lvl_i,
    .scl_idle_i, .sda_idle_i,
    .load_o(load), .loaded_o(loaded), .serial_en_o(serial_en), .init_o(init)
  );

  assign access_en = loaded && serial_en && (dev_addr_i == DEV_ADDR);

  cfg_regfile #(
    .NREG(NREG), .DW(DW), .AW(AW), .OFFS(REG_OFFS), .RST(REG_RST)
  ) u_rf (
    .clk_i, .rst_ni, .load_i(load), .init_i(init), .access_en_i(access_en),
    .wr_en_i(reg_wr_i), .rd_en_i(reg_rd_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .regs_o(regs), .rdata_o(reg_rdata_o)
  );

  assign edge_boost_o = regs[REG_EDGE][7:4];
  assign dc_boost_o   = regs[REG_DC][3:0];
  assign sens_o       = regs[REG_SENS];
  assign cfg_active_o = regs[REG_CFG][0];
  assign unused_bits  = ^{regs[REG_EDGE][3:0], regs[REG_DC][7:4], regs[REG_CFG][7:1]};

  p_normal_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && !serial_en) |-> !cfg_active_o);
  p_cfg_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (access_en && reg_wr_i && reg_addr_i == 8'h03 && !reg_wdata_i[0]) |=> !cfg_active_o);
  p_foreign_dev_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loaded && dev_addr_i != DEV_ADDR) |=> ($stable(sens_o) && $stable(edge_boost_o)));
endmodule

// File: tb/strap_cfg_regs_tb.sv
module strap_cfg_regs_tb;
  typedef struct packed {
    logic [1:0] boost; logic flt; logic [1:0] sens; logic scl; logic sda;
    logic [3:0] e_edge; logic [3:0] e_dc; logic [7:0] e_sens; logic e_cfg;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b0, 2'b00, 1'b0, 1'b0, 4'h0, 4'h0, 8'h00, 1'b0},
    '{2'd1, 1'b0, 2'b01, 1'b1, 1'b0, 4'h3, 4'h2, 8'h33, 1'b0},
    '{2'd2, 1'b0, 2'b10, 1'b0, 1'b1, 4'h6, 4'h2, 8'h66, 1'b0},
    '{2'd3, 1'b0, 2'b11, 1'b0, 1'b0, 4'hA, 4'h6, 8'h33, 1'b0},
    '{2'd0, 1'b1, 2'b00, 1'b1, 1'b1, 4'hA, 4'h6, 8'h00, 1'b1},
    '{2'd1, 1'b0, 2'b10, 1'b1, 1'b1, 4'h3, 4'h2, 8'h66, 1'b1},
    '{2'd2, 1'b1, 2'b01, 1'b0, 1'b0, 4'hA, 4'h6, 8'h33, 1'b0}
  };

  logic clk = 0, rst_ni = 0;
  logic [1:0] boost_lvl = 0, sens_lvl = 0;
  logic boost_float = 0, scl_idle = 0, sda_idle = 0;
  logic [6:0] dev_addr = 7'h2C;
  logic [7:0] reg_addr = 0, reg_wdata = 0, reg_rdata;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] edge_boost, dc_boost;
  logic [7:0] sens;
  logic cfg_active;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  strap_cfg_regs u_dut (
    .clk_i(clk), .rst_ni, .boost_lvl_i(boost_lvl), .boost_float_i(boost_float),
    .sens_lvl_i(sens_lvl), .scl_idle_i(scl_idle), .sda_idle_i(sda_idle),
    .dev_addr_i(dev_addr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_rdata_o(reg_rdata),
    .edge_boost_o(edge_boost), .dc_boost_o(dc_boost), .sens_o(sens),
    .cfg_active_o(cfg_active)
  );

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] b, input logic f, input logic [1:0] s,
                          input logic c, input logic d, input logic check_rst);
    @(negedge clk);
    rst_ni = 0; boost_lvl = b; boost_float = f; sens_lvl = s; scl_idle = c; sda_idle = d;
    @(negedge clk);
    if (check_rst) begin
      chk("R8 reset cfg_active", {7'h0, cfg_active}, 8'h01);
      chk("R1 reset edge", {4'h0, edge_boost}, 8'h00);
      chk("R3 reset sens", sens, 8'h00);
    end
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    reg_addr = a; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NV; i++) begin
      do_reset(VEC[i].boost, VEC[i].flt, VEC[i].sens, VEC[i].scl, VEC[i].sda, i == 0);
      chk(VEC[i].flt ? "R4 R1 edge" : "R1 edge", {4'h0, edge_boost}, {4'h0, VEC[i].e_edge});
      chk(VEC[i].flt ? "R4 R2 dc" : "R2 dc", {4'h0, dc_boost}, {4'h0, VEC[i].e_dc});
      chk("R3 sens", sens, VEC[i].e_sens);
      chk("R8 cfg_active", {7'h0, cfg_active}, {7'h0, VEC[i].e_cfg});
    end

    // serial mode, level 2, mid sensitivity
    do_reset(2'd2, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1);
    reg_addr = 8'h0E; reg_rd = 1;
    #1 chk("R10 rdata before edge", reg_rdata, 8'h00);
    @(negedge clk); reg_rd = 0;
    chk("R10 rdata after edge", reg_rdata, 8'h02);
    repeat (3) @(negedge clk);
    chk("R10 rdata hold", reg_rdata, 8'h02);

    boost_lvl = 2'd3; sens_lvl = 2'b10; boost_float = 1;
    repeat (4) @(negedge clk);
    chk("R5 edge after strap change", {4'h0, edge_boost}, 8'h06);
    chk("R5 sens after strap change", sens, 8'h33);

    wr(8'h01, 8'hC5);
    chk("R11 edge write", {4'h0, edge_boost}, 8'h0C);
    rd_reg(8'h01, rd); chk("R9 edge reserved readback", rd, 8'hC5);
    wr(8'h0E, 8'hF9);
    chk("R11 dc write", {4'h0, dc_boost}, 8'h09);
    rd_reg(8'h0E, rd); chk("R9 dc reserved readback", rd, 8'hF9);
    wr(8'h25, 8'h7E);
    chk("R11 sens write", sens, 8'h7E);

    dev_addr = 7'h2D;
    wr(8'h25, 8'h11);
    chk("R7 foreign write", sens, 8'h7E);
    rd_reg(8'h25, rd); chk("R7 foreign read", rd, 8'h00);
    dev_addr = 7'h2C;

    wr(8'h02, 8'hFF);
    rd_reg(8'h02, rd); chk("R9 unmapped read", rd, 8'h00);
    rd_reg(8'h25, rd); chk("R9 sens after unmapped write", rd, 8'h7E);
    rd_reg(8'h01, rd); chk("R9 edge after unmapped write", rd, 8'hC5);

    rd_reg(8'h03, rd); chk("R8 cfg read", rd, 8'h01);
    wr(8'h03, 8'hA0);
    chk("R8 cfg cleared", {7'h0, cfg_active}, 8'h00);
    rd_reg(8'h03, rd); chk("R9 cfg reserved readback", rd, 8'hA0);
    wr(8'h03, 8'h01);
    chk("R8 cfg set", {7'h0, cfg_active}, 8'h01);

    do_reset(2'd1, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
    wr(8'h25, 8'h55);
    chk("R6 locked write", sens, 8'h33);
    rd_reg(8'h25, rd); chk("R6 locked read", rd, 8'h00);
    wr(8'h03, 8'h01);
    chk("R6 locked cfg", {7'h0, cfg_active}, 8'h00);

    do_reset(2'd1, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0);
    wr(8'h01, 8'hF0);
    chk("R6 locked edge", {4'h0, edge_boost}, 8'h03);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule